// File: doc/BRIEF.md
# Prioritized Reference Clock Selector

This block decides which of six candidate reference inputs feeds a downstream clock-recovery loop. A 4-bit mode code either names one input outright (forced mode) or hands the choice to an automatic arbiter. In automatic mode, each input has three controls: a validity flag that an external quality qualifier drives, an active-low enable bit that software sets, and a 4-bit priority. The block picks the best-ranked input among those that qualify.

The result is registered. It is presented as a zero-based index together with a flag that means no input is selected. A one-cycle strobe marks every change of either output, so the loop controller can react to a switchover.

Top module: `refclk_selector`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sel_idx` is 0, `sel_none` is 1 and `sel_changed` is 0.
- R2: Mode code 4'b0000 selects automatic mode.
- R3: Mode codes 4'b0011 to 4'b0110 force inputs 1 to 4, which are reported as `sel_idx` 0 to 3. Codes 4'b1001 and 4'b1010 force inputs 5 and 6, reported as `sel_idx` 4 and 5. In each case `sel_none` is 0.
- R4: In forced mode, the selection does not depend on `ref_valid`, `ref_disable` or `ref_prio`.
- R5: The mode codes 4'b0001, 4'b0010, 4'b0111, 4'b1000 and 4'b1011 to 4'b1111 are reserved. Each of them gives `sel_none` = 1 and `sel_idx` = 0.
- R6: In automatic mode, input k (bit k-1 of each vector, priority field `ref_prio[4k-1:4k-4]`) takes part only if `ref_valid` is 1, `ref_disable` is 0 and its priority is not 4'b0000.
- R7: An input whose `ref_disable` bit is 1 is never chosen automatically. With all six bits at 1, which is the value the mask register holds after reset, automatic mode selects nothing.
- R8: Among the inputs that take part, the smallest nonzero priority value wins (1 is the best and 15 the worst).
- R9: When two inputs that take part share the best priority, the lower-numbered input wins.
- R10: In automatic mode with no input taking part, `sel_none` is 1 and `sel_idx` is 0.
- R11: The outputs follow a change of the inputs at the next rising clock edge, and not before it.
- R12: `sel_changed` is 1 for exactly the cycle after an edge that changed `sel_idx` or `sel_none`. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | 4 | Automatic, forced or reserved selection code |
| ref_valid | input | 6 | Per-input validity from the quality qualifier, bit k-1 for input k |
| ref_disable | input | 6 | Per-input active-low enable (1 excludes the input from automatic mode) |
| ref_prio | input | 24 | Six 4-bit priorities, input k in bits 4k-1:4k-4 |
| sel_idx | output | 3 | Registered zero-based index of the selected input |
| sel_none | output | 1 | Registered flag that no input is selected |
| sel_changed | output | 1 | One-cycle strobe on any change of `sel_idx` or `sel_none` |

## Verification
The hardest case to reach from the ports is one where the arbiter's answer changes but the registered outputs do not. Examples are switching from forced input 1 to automatic mode with input 1 winning, or swapping which qualifier condition disqualifies an input while the winner stays the same. In these cases `sel_changed` must stay low. The bench builds such transitions deliberately in its strobe task. Equal-priority ties and zero priorities on otherwise qualified inputs are arranged explicitly. A sweep of pseudo-random vectors then compares every cycle against a model written from the requirements.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  // Mode-code constants; the forced ranges are part of the block's behaviour.
  localparam int MODE_AUTO   = 0;
  localparam int FRC_A_FIRST = 3;   // forces input 1
  localparam int FRC_A_LAST  = 6;   // forces input 4
  localparam int FRC_B_FIRST = 9;   // forces input 5
  localparam int FRC_B_LAST  = 10;  // forces input 6
  localparam int FRC_B_BASE  = 4;   // zero-based index of first input in range B

  typedef enum logic [1:0] {
    KIND_AUTO     = 2'd0,
    KIND_FORCED   = 2'd1,
    KIND_RESERVED = 2'd2
  } sel_kind_t;
endpackage

// File: rtl/refsel_mode_decode.sv
module refsel_mode_decode
  import refsel_pkg::*;
#(
  parameter int MODE_W     = 4,
  parameter int NUM_INPUTS = 6,
  parameter int IDX_W      = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
  input  logic [MODE_W-1:0] mode_code,
  output sel_kind_t         kind,
  output logic [IDX_W-1:0]  force_idx
);
  int code;
  int target;

  always_comb begin
    code      = int'(mode_code);
    target    = 0;
    kind      = KIND_RESERVED;
    force_idx = '0;
    if (code == MODE_AUTO) begin
      kind = KIND_AUTO;
    end else begin
      if (code >= FRC_A_FIRST && code <= FRC_A_LAST) begin
        target = code - FRC_A_FIRST;
        kind   = KIND_FORCED;
      end else if (code >= FRC_B_FIRST && code <= FRC_B_LAST) begin
        target = code - FRC_B_FIRST + FRC_B_BASE;
        kind   = KIND_FORCED;
      end
      // A forced code naming an input that is not built counts as reserved.
      if (kind == KIND_FORCED && target >= NUM_INPUTS) begin
        kind = KIND_RESERVED;
      end else if (kind == KIND_FORCED) begin
        force_idx = IDX_W'(target);
      end
    end
  end
endmodule

// File: rtl/refsel_arbiter.sv
module refsel_arbiter #(
  parameter int NUM_INPUTS = 6,
  parameter int PRIO_W     = 4,
  parameter int IDX_W      = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
  input  logic [NUM_INPUTS-1:0]        valid,
  input  logic [NUM_INPUTS-1:0]        disable_n_en,
  input  logic [NUM_INPUTS*PRIO_W-1:0] prio,
  output logic                         found,
  output logic [IDX_W-1:0]             win_idx
);
  logic [NUM_INPUTS-1:0] qual;
  logic [PRIO_W-1:0]     best;

  for (genvar g = 0; g < NUM_INPUTS; g++) begin : g_qual
    assign qual[g] = valid[g] & ~disable_n_en[g] & (prio[g*PRIO_W +: PRIO_W] != '0);
  end

  // Ascending scan with strict compare: lowest value wins, ties go to lower index.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '1;
    for (int i = 0; i < NUM_INPUTS; i++) begin
      if (qual[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        best    = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
  import refsel_pkg::*;
#(
  parameter int NUM_INPUTS = 6,
  parameter int PRIO_W     = 4,
  parameter int MODE_W     = 4,
  localparam int IDX_W     = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1,
  localparam int PRIO_BUS  = NUM_INPUTS * PRIO_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [MODE_W-1:0]     mode_code,
  input  logic [NUM_INPUTS-1:0] ref_valid,
  input  logic [NUM_INPUTS-1:0] ref_disable,
  input  logic [PRIO_BUS-1:0]   ref_prio,
  output logic [IDX_W-1:0]      sel_idx,
  output logic                  sel_none,
  output logic                  sel_changed
);
  sel_kind_t        kind;
  logic [IDX_W-1:0] force_idx;
  logic             arb_found;
  logic [IDX_W-1:0] arb_idx;
  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_none;

  refsel_mode_decode #(
    .MODE_W(MODE_W), .NUM_INPUTS(NUM_INPUTS), .IDX_W(IDX_W)
  ) u_dec (
    .mode_code(mode_code), .kind(kind), .force_idx(force_idx)
  );

  refsel_arbiter #(
    .NUM_INPUTS(NUM_INPUTS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_arb (
    .valid(ref_valid), .disable_n_en(ref_disable), .prio(ref_prio),
    .found(arb_found), .win_idx(arb_idx)
  );

  always_comb begin
    unique case (kind)
      KIND_FORCED: begin nxt_idx = force_idx; nxt_none = 1'b0; end
      KIND_AUTO: begin
        nxt_idx  = arb_found ? arb_idx : '0;
        nxt_none = ~arb_found;
      end
      default: begin nxt_idx = '0; nxt_none = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx     <= '0;
      sel_none    <= 1'b1;
      sel_changed <= 1'b0;
    end else begin
      sel_idx     <= nxt_idx;
      sel_none    <= nxt_none;
      sel_changed <= (nxt_idx != sel_idx) || (nxt_none != sel_none);
    end
  end

  // Assertions
  AST_FORCE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (int'(mode_code) == FRC_A_FIRST) |=> (sel_idx == '0 && !sel_none)); // R3
  AST_FORCE_NEVER_NONE: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_FORCED) |=> !sel_none); // R4
  AST_RESERVED_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_RESERVED) |=> (sel_none && sel_idx == '0)); // R5
  AST_WINNER_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    arb_found |-> (ref_valid[arb_idx] && !ref_disable[arb_idx]
                   && ref_prio[arb_idx*PRIO_W +: PRIO_W] != '0)); // R6
  AST_ALL_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_AUTO && &ref_disable) |=> sel_none); // R7
  AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (rst)
    sel_changed == ((sel_idx != $past(sel_idx)) || (sel_none != $past(sel_none)))); // R12
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(sel_idx) < NUM_INPUTS); // R3
endmodule

// File: tb/refclk_selector_test.sv
module refclk_selector_test;
  localparam int N = 6;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  mode_code;
  logic [5:0]  ref_valid;
  logic [5:0]  ref_disable;
  logic [23:0] ref_prio;
  logic [2:0]  sel_idx;
  logic        sel_none;
  logic        sel_changed;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk; // 125 MHz

  refclk_selector uut (
    .clk(clk), .rst(rst), .mode_code(mode_code), .ref_valid(ref_valid),
    .ref_disable(ref_disable), .ref_prio(ref_prio),
    .sel_idx(sel_idx), .sel_none(sel_none), .sel_changed(sel_changed)
  );

  // Model written from the requirements; returns {none, idx}.
  function automatic logic [3:0] model(input logic [3:0] m, input logic [5:0] v,
                                       input logic [5:0] d, input logic [23:0] p);
    int best = 16;
    int win  = -1;
    if (m >= 4'd3 && m <= 4'd6) return {1'b0, 3'(m - 4'd3)};
    if (m == 4'd9 || m == 4'd10) return {1'b0, 3'(m - 4'd5)};
    if (m != 4'd0) return 4'b1000;
    for (int i = 0; i < N; i++) begin
      if (v[i] && !d[i] && p[i*4 +: 4] != 4'd0 && int'(p[i*4 +: 4]) < best) begin
        best = int'(p[i*4 +: 4]);
        win  = i;
      end
    end
    if (win < 0) return 4'b1000;
    return {1'b0, 3'(win)};
  endfunction

  task automatic check(input string tag, input logic [2:0] exp_idx, input logic exp_none);
    checks++;
    if (sel_idx !== exp_idx || sel_none !== exp_none) begin
      fails++;
      $display("FAIL %s: idx=%0d none=%0b expected idx=%0d none=%0b",
               tag, sel_idx, sel_none, exp_idx, exp_none);
    end
  endtask

  task automatic check_strobe(input string tag, input logic exp);
    checks++;
    if (sel_changed !== exp) begin
      fails++;
      $display("FAIL %s: sel_changed=%0b expected %0b", tag, sel_changed, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic apply(input logic [3:0] m, input logic [5:0] v,
                       input logic [5:0] d, input logic [23:0] p);
    @(negedge clk);
    mode_code = m; ref_valid = v; ref_disable = d; ref_prio = p;
    @(negedge clk);
  endtask

  function automatic logic [23:0] prios(input int p1, input int p2, input int p3,
                                        input int p4, input int p5, input int p6);
    return {4'(p6), 4'(p5), 4'(p4), 4'(p3), 4'(p2), 4'(p1)};
  endfunction

  task automatic t_reset();
    rst = 1'b1; mode_code = 4'd3; ref_valid = '1; ref_disable = '1; ref_prio = '1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'd0, 1'b1);
    check_strobe("R1 strobe in reset", 1'b0);
    mode_code = 4'd0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle after reset", 3'd0, 1'b1);
    check_strobe("R1 no strobe after reset", 1'b0);
  endtask

  task automatic t_forced();
    for (int c = 3; c <= 6; c++) begin
      apply(4'(c), 6'b000000, 6'b111111, 24'h0);
      check("R3 forced range A", 3'(c - 3), 1'b0);
    end
    apply(4'd9, 6'b0, 6'b111111, 24'h0);
    check("R3 forced input 5", 3'd4, 1'b0);
    apply(4'd10, 6'b0, 6'b111111, 24'h0);
    check("R3 forced input 6", 3'd5, 1'b0);
    // R4: best automatic candidate is input 1, forced selection must stay on input 4.
    apply(4'd6, 6'b111111, 6'b000000, prios(1, 2, 3, 4, 5, 6));
    check("R4 forced ignores qualifiers", 3'd3, 1'b0);
    apply(4'd6, 6'b000000, 6'b000000, prios(0, 0, 0, 0, 0, 0));
    check("R4 forced with nothing valid", 3'd3, 1'b0);
  endtask

  task automatic t_reserved();
    logic [3:0] codes[9] = '{4'd1, 4'd2, 4'd7, 4'd8, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
    for (int k = 0; k < 9; k++) begin
      apply(4'd4, 6'b111111, 6'b0, prios(1, 1, 1, 1, 1, 1));
      apply(codes[k], 6'b111111, 6'b0, prios(1, 1, 1, 1, 1, 1));
      check($sformatf("R5 reserved code %0d", codes[k]), 3'd0, 1'b1);
    end
  endtask

  task automatic t_auto();
    apply(4'd0, 6'b111111, 6'b000000, prios(9, 7, 3, 8, 5, 12));
    check("R2 R8 automatic picks smallest priority", 3'd2, 1'b0);
    apply(4'd0, 6'b111011, 6'b000000, prios(9, 7, 3, 8, 5, 12));
    check("R6 invalid input skipped", 3'd4, 1'b0);
    apply(4'd0, 6'b111111, 6'b000000, prios(9, 7, 0, 8, 5, 12));
    check("R6 zero priority skipped", 3'd4, 1'b0);
    apply(4'd0, 6'b111111, 6'b010100, prios(9, 7, 3, 8, 5, 12));
    check("R7 disabled inputs skipped", 3'd1, 1'b0);
    apply(4'd0, 6'b111111, 6'b111111, prios(1, 1, 1, 1, 1, 1));
    check("R7 all disabled selects nothing", 3'd0, 1'b1);
    apply(4'd0, 6'b111111, 6'b000000, prios(15, 15, 15, 15, 15, 1));
    check("R8 priority 1 on input 6", 3'd5, 1'b0);
    apply(4'd0, 6'b111111, 6'b000001, prios(4, 6, 9, 2, 7, 2));
    check("R9 tie goes to lower input", 3'd3, 1'b0);
    apply(4'd0, 6'b100001, 6'b000000, prios(15, 1, 1, 1, 1, 15));
    check("R9 tie at worst priority", 3'd0, 1'b0);
    apply(4'd0, 6'b000000, 6'b000000, prios(1, 2, 3, 4, 5, 6));
    check("R10 none qualified", 3'd0, 1'b1);
  endtask

  task automatic t_latency_strobe();
    apply(4'd5, 6'b0, 6'b0, 24'h0);             // forced input 3, idx 2
    @(negedge clk);
    check_strobe("R12 steady inputs no strobe", 1'b0);
    mode_code = 4'd9;                           // change mid-cycle
    #2;
    check("R11 output holds before edge", 3'd2, 1'b0);
    @(negedge clk);
    check("R11 output follows after edge", 3'd4, 1'b0);
    check_strobe("R12 strobe on index change", 1'b1);
    @(negedge clk);
    check_strobe("R12 strobe lasts one cycle", 1'b0);
    // Same index from a different route: forced input 1 then automatic winner input 1.
    apply(4'd3, 6'b0, 6'b0, 24'h0);
    apply(4'd0, 6'b000001, 6'b0, prios(3, 0, 0, 0, 0, 0));
    check("R12 route change same index", 3'd0, 1'b0);
    check_strobe("R12 no strobe when outputs equal", 1'b0);
    apply(4'd0, 6'b000000, 6'b0, prios(3, 0, 0, 0, 0, 0));
    check_strobe("R12 strobe when none flag rises", 1'b1);
    apply(4'd2, 6'b000000, 6'b0, 24'h0);        // reserved: same none/idx
    check_strobe("R12 no strobe none to none", 1'b0);
  endtask

  task automatic t_sweep();
    logic [3:0] exp;
    logic [2:0] prev_idx;
    logic       prev_none;
    for (int k = 0; k < 400; k++) begin
      prev_idx = sel_idx; prev_none = sel_none;
      apply((k % 3 == 0) ? 4'($urandom_range(0, 15)) : 4'd0, 6'($urandom),
            6'($urandom) & 6'($urandom), 24'($urandom));
      exp = model(mode_code, ref_valid, ref_disable, ref_prio);
      check("R2 R6 R8 R9 sweep", exp[2:0], exp[3]);
      check_strobe("R12 sweep strobe", (exp[2:0] != prev_idx) || (exp[3] != prev_none));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_forced();
    t_reserved();
    t_auto();
    t_latency_strobe();
    t_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule